// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block holds a handful of core control and status words behind a simple single-cycle register port. The main control word carries the priority-grouping field and the system-reset request, and it accepts a write only when the upper half of the written data holds the unlock key. A read of the same word returns a different, fixed key value in its upper half. Software can therefore tell a successful read from a stale bus value. A write carrying any other key is dropped without effect.

Two fault-status words collect sticky fault indications from the core through set inputs. Software clears them by writing ones. A set and a clear that meet on the same bit in the same cycle leave the bit set. A configuration word accepts writes only to the bits its mask allows. It raises a one-cycle notice whenever its unaligned-access trap bit changes. The control word does the same when the priority grouping changes value, so that the downstream priority logic knows to re-evaluate.

Writes and reads use separate address inputs. Write data is taken at the rising clock edge. Read data is a combinational function of the read address and the stored state.

Top module: `scr_ctrl_bank`

## Requirements
- R1: A write to the control word (offset 0) changes its state only when data bits 31:16 equal 0x05FA. Any other key leaves the grouping, the reset request and the refresh output unchanged.
- R2: A read of the control word returns 0xFA05 in bits 31:16 and the constant endianness parameter in bit 15. It returns the grouping in bits 10:8, the reset request in bit 2, and zero elsewhere. Writing bit 15 has no effect.
- R3: After reset the grouping and the reset request are 0, the refresh output is 0, and the control word reads 0xFA050000.
- R4: An accepted write that changes the grouping stores the new value and pulses `prio_refresh` high for exactly the next cycle. An accepted write with an equal grouping gives no pulse.
- R5: An accepted write stores data bit 2 as the reset request, and `sys_reset_req` follows the stored bit as a level.
- R6: Writing to either fault word (offsets 2 and 3) clears every bit written as 1 and leaves bits written as 0 unchanged. A 1 on a fault set input sets that bit at the next edge and it stays set.
- R7: After reset fault word 0 reads 0xFFFFFFFF and fault word 1 reads 0x00000000.
- R8: The configuration word (offset 1) resets to 0x00000200. A write updates only the bits in the write mask (default 0x0000031B), and the word is visible on `cfg_ctrl`.
- R9: `trap_chg` pulses high for exactly one cycle after a write that flips configuration bit 3 (the unaligned-trap bit), and stays low otherwise.
- R10: When a fault set input and a software clear hit the same bit in the same cycle, the bit ends up set.
- R11: Reads of offsets 4 and above return 0, and writes to them change no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | ADDR_W | Word offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word offset of the read |
| rd_data | output | 32 | Combinational read data |
| fault0_set | input | 32 | Sticky set bits for fault word 0 |
| fault1_set | input | 32 | Sticky set bits for fault word 1 |
| sys_reset_req | output | 1 | System reset request level |
| prio_group | output | 3 | Stored priority grouping |
| prio_refresh | output | 1 | One-cycle pulse on grouping change |
| cfg_ctrl | output | 32 | Configuration word |
| trap_chg | output | 1 | One-cycle pulse on unaligned-trap bit change |

## Verification
The bench builds the block with its defaults: a 4-bit address, the 0x0000031B configuration mask, the trap bit at position 3 and endianness 0. With a 4-bit address every offset can be swept, including all twelve unmapped ones. The 16-bit key field is small enough to try all 65536 keys, and each try carries a grouping and reset request derived from the key. Every one of the 64 grouping transitions is also covered. Fault words are cleared one bit at a time and the configuration word is written one bit at a time. The bench predicts each result with mask arithmetic.

// File: rtl/scr_pkg.sv
`timescale 1ns/1ps
package scr_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned KEY_W    = 16;
    localparam int unsigned KEY_LSB  = 16;
    localparam int unsigned GRP_W    = 3;
    localparam int unsigned GRP_LSB  = 8;
    localparam int unsigned SRQ_BIT  = 2;

    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h05FA;
    localparam logic [KEY_W-1:0] READ_KEY   = 16'hFA05;

    localparam int unsigned OFS_CTL  = 0;
    localparam int unsigned OFS_CFG  = 1;
    localparam int unsigned OFS_FLT0 = 2;
    localparam int unsigned OFS_FLT1 = 3;
    localparam int unsigned NUM_FLT  = 2;

    typedef struct packed {
        logic [GRP_W-1:0] grp;
        logic             srq;
        logic             refresh;
    } ctl_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              chg;
    } cfg_state_t;

endpackage

// File: rtl/scr_keyed_ctl.sv
`timescale 1ns/1ps
module scr_keyed_ctl
    import scr_pkg::*;
#(
    parameter logic END_VAL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [GRP_W-1:0]  grp,
    output logic              srq,
    output logic              refresh,
    output logic [WORD_W-1:0] rd_word
);

    ctl_state_t st_d, st_q;
    logic       key_ok;
    logic [GRP_W-1:0] grp_new;

    assign key_ok  = (wdata[KEY_LSB +: KEY_W] == UNLOCK_KEY);
    assign grp_new = wdata[GRP_LSB +: GRP_W];

    always_comb begin
        st_d         = st_q;
        st_d.refresh = 1'b0;
        if (wr && key_ok) begin
            st_d.srq = wdata[SRQ_BIT];
            if (grp_new != st_q.grp) begin
                st_d.grp     = grp_new;
                st_d.refresh = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grp     = st_q.grp;
    assign srq     = st_q.srq;
    assign refresh = st_q.refresh;
    assign rd_word = {READ_KEY, END_VAL, 4'b0000, st_q.grp, 5'b00000, st_q.srq, 2'b00};

endmodule

// File: rtl/scr_cfg_reg.sv
`timescale 1ns/1ps
module scr_cfg_reg
    import scr_pkg::*;
#(
    parameter logic [WORD_W-1:0] RST_VAL  = 32'h0000_0200,
    parameter logic [WORD_W-1:0] WMASK    = 32'h0000_031B,
    parameter int unsigned       TRAP_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] word,
    output logic              chg
);

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.word = (st_q.word & ~WMASK) | (wdata & WMASK);
        end
        st_d.chg = (st_d.word[TRAP_BIT] != st_q.word[TRAP_BIT]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word <= RST_VAL;
            st_q.chg  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.word;
    assign chg  = st_q.chg;

endmodule

// File: rtl/scr_w1c_bank.sv
`timescale 1ns/1ps
module scr_w1c_bank
    import scr_pkg::*;
#(
    parameter int unsigned               NUM      = 2,
    parameter logic [NUM*WORD_W-1:0]     RST_VALS = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM-1:0]           wr_sel,
    input  logic [WORD_W-1:0]        wdata,
    input  logic [NUM*WORD_W-1:0]    set_in,
    output logic [NUM*WORD_W-1:0]    words
);

    logic [WORD_W-1:0] words_d [NUM];
    logic [WORD_W-1:0] words_q [NUM];

    always_comb begin
        for (int i = 0; i < NUM; i++) begin
            words_d[i] = words_q[i];
            if (wr_sel[i]) begin
                words_d[i] = words_d[i] & ~wdata;
            end
            // set after clear: hardware capture wins
            words_d[i] = words_d[i] | set_in[i*WORD_W +: WORD_W];
        end
    end

    for (genvar g = 0; g < NUM; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words_q[g] <= RST_VALS[g*WORD_W +: WORD_W];
            end else begin
                words_q[g] <= words_d[g];
            end
        end
        assign words[g*WORD_W +: WORD_W] = words_q[g];
    end

endmodule

// File: rtl/scr_ctrl_bank.sv
`timescale 1ns/1ps
module scr_ctrl_bank
    import scr_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 4,
    parameter logic [31:0]       CFG_MASK = 32'h0000_031B,
    parameter int unsigned       TRAP_BIT = 3,
    parameter logic              END_VAL  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [31:0]       fault0_set,
    input  logic [31:0]       fault1_set,
    output logic              sys_reset_req,
    output logic [2:0]        prio_group,
    output logic              prio_refresh,
    output logic [31:0]       cfg_ctrl,
    output logic              trap_chg
);

    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_FLT0 = ADDR_W'(OFS_FLT0);
    localparam logic [ADDR_W-1:0] A_FLT1 = ADDR_W'(OFS_FLT1);
    localparam logic [NUM_FLT*WORD_W-1:0] FLT_RST = {32'h0000_0000, 32'hFFFF_FFFF};

    logic                      wr_ctl, wr_cfg;
    logic [NUM_FLT-1:0]        wr_flt;
    logic [WORD_W-1:0]         ctl_word;
    logic [NUM_FLT*WORD_W-1:0] flt_words;

    assign wr_ctl    = wr_en && (wr_addr == A_CTL);
    assign wr_cfg    = wr_en && (wr_addr == A_CFG);
    assign wr_flt[0] = wr_en && (wr_addr == A_FLT0);
    assign wr_flt[1] = wr_en && (wr_addr == A_FLT1);

    scr_keyed_ctl #(.END_VAL(END_VAL)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_ctl),
        .wdata   (wr_data),
        .grp     (prio_group),
        .srq     (sys_reset_req),
        .refresh (prio_refresh),
        .rd_word (ctl_word)
    );

    scr_cfg_reg #(
        .RST_VAL  (32'h0000_0200),
        .WMASK    (CFG_MASK),
        .TRAP_BIT (TRAP_BIT)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_cfg),
        .wdata (wr_data),
        .word  (cfg_ctrl),
        .chg   (trap_chg)
    );

    scr_w1c_bank #(
        .NUM      (NUM_FLT),
        .RST_VALS (FLT_RST)
    ) u_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (wr_flt),
        .wdata  (wr_data),
        .set_in ({fault1_set, fault0_set}),
        .words  (flt_words)
    );

    always_comb begin
        case (rd_addr)
            A_CTL:   rd_data = ctl_word;
            A_CFG:   rd_data = cfg_ctrl;
            A_FLT0:  rd_data = flt_words[0 +: WORD_W];
            A_FLT1:  rd_data = flt_words[WORD_W +: WORD_W];
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/scr_ctrl_bank_chk.sv
`timescale 1ns/1ps
module scr_ctrl_bank_chk #(
    parameter int unsigned ADDR_W   = 4,
    parameter logic [31:0] CFG_MASK = 32'h0000_031B,
    parameter int unsigned TRAP_BIT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [31:0]       rd_data,
    input logic [31:0]       fault0_set,
    input logic [31:0]       flt_words0,
    input logic              sys_reset_req,
    input logic [2:0]        prio_group,
    input logic              prio_refresh,
    input logic [31:0]       cfg_ctrl,
    input logic              trap_chg
);

    logic ctl_wr, key_ok, cfg_wr;
    assign ctl_wr = wr_en && (wr_addr == '0);
    assign cfg_wr = wr_en && (wr_addr == ADDR_W'(1));
    assign key_ok = (wr_data[31:16] == 16'h05FA);

    assert_bad_key_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !key_ok) |=> ($stable(prio_group) && $stable(sys_reset_req) && !prio_refresh));

    assert_read_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == '0) |-> (rd_data[31:16] == 16'hFA05));

    assert_refresh_on_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prio_refresh |-> (prio_group != $past(prio_group)));

    assert_srq_follows_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && key_ok) |=> (sys_reset_req == $past(wr_data[2])));

    assert_cfg_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (((cfg_ctrl ^ $past(cfg_ctrl)) & ~CFG_MASK) == 32'h0));

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(cfg_ctrl));

    assert_trap_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_chg |-> (cfg_ctrl[TRAP_BIT] != $past(cfg_ctrl[TRAP_BIT])));

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault0_set != 32'h0) |=> ((flt_words0 & $past(fault0_set)) == $past(fault0_set)));

endmodule

bind scr_ctrl_bank scr_ctrl_bank_chk #(
    .ADDR_W   (ADDR_W),
    .CFG_MASK (CFG_MASK),
    .TRAP_BIT (TRAP_BIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .fault0_set    (fault0_set),
    .flt_words0    (flt_words[31:0]),
    .sys_reset_req (sys_reset_req),
    .prio_group    (prio_group),
    .prio_refresh  (prio_refresh),
    .cfg_ctrl      (cfg_ctrl),
    .trap_chg      (trap_chg)
);

// File: tb/test_scr_ctrl_bank.sv
`timescale 1ns/1ps
module test_scr_ctrl_bank;

    localparam logic [31:0] MASK = 32'h0000_031B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] fault0_set = '0;
    logic [31:0] fault1_set = '0;
    logic        sys_reset_req;
    logic [2:0]  prio_group;
    logic        prio_refresh;
    logic [31:0] cfg_ctrl;
    logic        trap_chg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    scr_ctrl_bank i_scr_ctrl_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .fault0_set(fault0_set), .fault1_set(fault1_set),
        .sys_reset_req(sys_reset_req), .prio_group(prio_group),
        .prio_refresh(prio_refresh), .cfg_ctrl(cfg_ctrl), .trap_chg(trap_chg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    function automatic logic [31:0] ctl_val(input logic [2:0] g, input logic s);
        return {16'hFA05, 1'b0, 4'b0, g, 5'b0, s, 2'b0};
    endfunction

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, exp_f, exp_c, old_c;
        logic [2:0]  eg;
        logic        es, acc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3, R7, R8 reset values
        rd(0, v); check("R3 ctl reset read", v, 32'hFA05_0000);
        check("R3 grouping reset", {29'b0, prio_group}, 0);
        check("R3 srq reset", {31'b0, sys_reset_req}, 0);
        check("R3 refresh reset", {31'b0, prio_refresh}, 0);
        rd(2, v); check("R7 fault0 reset", v, 32'hFFFF_FFFF);
        rd(3, v); check("R7 fault1 reset", v, 32'h0);
        rd(1, v); check("R8 cfg reset", v, 32'h0000_0200);
        check("R8 cfg port reset", cfg_ctrl, 32'h0000_0200);

        // R11 unmapped reads
        for (int a = 4; a < 16; a++) begin
            rd(4'(a), v); check("R11 unmapped read", v, 0);
        end

        // R1, R2, R5: every key, low half derived from the key, bit 15 set
        eg = 0; es = 0;
        for (int k = 0; k < 65536; k++) begin
            logic [15:0] kk;
            logic [2:0]  g;
            kk = 16'(k);
            g  = kk[2:0];
            acc = (kk == 16'h05FA);
            wr(0, {kk, 1'b1, 4'b0, g, 5'b0, kk[3], 2'b0});
            rd(0, v);
            check("R1 R2 ctl after keyed write", v,
                  ctl_val(acc ? g : eg, acc ? kk[3] : es));
            check("R1 R4 refresh after keyed write", {31'b0, prio_refresh},
                  {31'b0, acc && (g != eg)});
            if (acc) begin eg = g; es = kk[3]; end
            check("R5 srq level", {31'b0, sys_reset_req}, {31'b0, es});
        end

        // R4 all grouping transitions
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                wr(0, {16'h05FA, 5'b0, 3'(a), 8'b0});
                wr(0, {16'h05FA, 5'b0, 3'(b), 8'b0});
                check("R4 grouping stored", {29'b0, prio_group}, 32'(b));
                check("R4 pulse on change", {31'b0, prio_refresh}, {31'b0, a != b});
                @(negedge clk);
                check("R4 pulse one cycle", {31'b0, prio_refresh}, 0);
            end
        end

        // R5 explicit set and clear
        wr(0, {16'h05FA, 16'h0004});
        check("R5 srq set", {31'b0, sys_reset_req}, 1);
        wr(0, {16'h05FA, 16'h0000});
        check("R5 srq clear", {31'b0, sys_reset_req}, 0);

        // R6 fault0 cleared bit by bit, with a zero write in between
        exp_f = 32'hFFFF_FFFF;
        for (int i = 0; i < 32; i++) begin
            wr(2, 32'h0);
            rd(2, v); check("R6 zero write keeps fault0", v, exp_f);
            exp_f = exp_f & ~(32'h1 << i);
            wr(2, 32'h1 << i);
            rd(2, v); check("R6 fault0 w1c", v, exp_f);
        end

        // R6 sticky set on fault1 then clear by patterns
        fault1_set = 32'hA5A5_0F0F;
        @(negedge clk);
        fault1_set = 32'h0;
        @(negedge clk);
        rd(3, v); check("R6 fault1 sticky set", v, 32'hA5A5_0F0F);
        wr(3, 32'hFFFF_0000);
        rd(3, v); check("R6 fault1 w1c upper", v, 32'h0000_0F0F);
        wr(3, 32'h0000_0101);
        rd(3, v); check("R6 fault1 w1c partial", v, 32'h0000_0E0E);

        // R10 set wins over clear in the same cycle
        fault0_set = 32'h0000_00F0;
        wr(2, 32'h0000_0FF0);
        fault0_set = 32'h0;
        rd(2, v); check("R10 set beats clear", v, 32'h0000_00F0);
        fault0_set = 32'h0000_0F00;
        wr(2, 32'h0000_00F0);
        fault0_set = 32'h0;
        rd(2, v); check("R10 set with other clear", v, 32'h0000_0F00);

        // R8, R9 configuration single-bit writes
        exp_c = 32'h0000_0200;
        for (int i = 0; i < 32; i++) begin
            old_c = exp_c;
            exp_c = (exp_c & ~MASK) | ((32'h1 << i) & MASK);
            wr(1, 32'h1 << i);
            rd(1, v); check("R8 cfg masked write", v, exp_c);
            check("R8 cfg port", cfg_ctrl, exp_c);
            check("R9 trap pulse", {31'b0, trap_chg}, {31'b0, exp_c[3] != old_c[3]});
            @(negedge clk);
            check("R9 trap pulse one cycle", {31'b0, trap_chg}, 0);
        end
        wr(1, 32'hFFFF_FFFF);
        check("R8 cfg all ones", cfg_ctrl, MASK);
        check("R9 trap rise", {31'b0, trap_chg}, 1);
        wr(1, 32'hFFFF_FFFF);
        check("R9 no pulse when unchanged", {31'b0, trap_chg}, 0);

        // R11 writes to unmapped offsets change nothing
        wr(0, {16'h05FA, 16'h0504});
        for (int a = 4; a < 16; a++) begin
            wr(4'(a), 32'hFFFF_FFFF);
            wr(4'(a), {16'h05FA, 16'h0000});
        end
        rd(0, v); check("R11 ctl untouched", v, ctl_val(3'd5, 1'b1));
        rd(1, v); check("R11 cfg untouched", v, MASK);
        rd(2, v); check("R11 fault0 untouched", v, 32'h0000_0F00);
        rd(3, v); check("R11 fault1 untouched", v, 32'h0000_0E0E);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule